// File: doc/BRIEF.md
# In-Lane Vector Shuffle and Permute Unit

This datapath block rearranges the 32-bit and 64-bit elements of 256-bit vectors. Each request carries two source vectors, a selector vector for the variable permutes, an 8-bit immediate, a 4-bit operation code and a width flag. The block registers exactly one result for each request. The result appears one clock after the request, with a valid strobe that tracks the request strobe.

The vector is split into 128-bit lanes. Every element selection except the half-route operation draws only from the same lane of its sources. The half-route operation builds each 128-bit half of the result from any half of either source, or from zero. When the width flag marks a 128-bit request, the upper half of the result is cleared. The half-route operation is the exception and always writes all 256 bits.

A pipeline front end uses the block for in-lane permutes. It drives one request per cycle and takes the registered result.

The datapath has no state machine. Its only state is the output register stage, with two conditions. In the idle condition the valid strobe is low and the data holds. In the loaded condition the valid strobe is high and the data was captured at the last edge.

Top module: `shp_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. A synchronous reset clears `out_valid`, `out_data` and `out_err`. While `in_valid` is low, `out_data` holds its value.
- R2: Code 0 (interleave low) gives, per lane, dwords {b1, a1, b0, a0}, with the highest dword listed first.
- R3: Code 1 (interleave high) gives, per lane, dwords {b3, a3, b2, a2}.
- R4: Code 2 (two-source dword shuffle) works per lane. Result dword p takes source dword imm[2p+1:2p], from source A for p = 0 and 1 and from source B for p = 2 and 3. The same immediate serves every lane.
- R5: Code 3 (two-source qword shuffle) uses imm bits 2k and 2k+1 in lane k. Bit 2k picks the A qword for output qword 0. Bit 2k+1 picks the B qword for output qword 1.
- R6: Code 4 permutes the dwords of A by immediate: dword p takes A dword imm[2p+1:2p] of the same lane. Code 5 permutes the qwords of A: in lane k, output qword q takes A qword imm[2k+q].
- R7: Code 6 permutes the dwords of A by selector. Dword p takes the A dword indexed by bits 1:0 of selector dword p, and all other selector bits are ignored.
- R8: Code 7 permutes the qwords of A by selector. Qword q takes the A qword indexed by bit 1 of the low dword of selector qword q, and all other selector bits are ignored.
- R9: Code 8 (half route) uses immediate nibble h to build result half h. Nibble bit 3 zeroes the half. Otherwise bit 1 selects source B (1) or A (0), and bit 0 selects that source's upper (1) or lower (0) half.
- R10: With `in_wide` = 0, bits 255:128 of the result are zero for every code except 8. Code 8 writes all 256 bits whatever `in_wide` is.
- R11: Codes 9 to 15 give an all-zero result with `out_err` = 1. Codes 0 to 8 give `out_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_wide | input | 1 | 1 = 256-bit request, 0 = 128-bit request |
| in_imm | input | 8 | Immediate control byte |
| in_src_a | input | 256 | First source vector |
| in_src_b | input | 256 | Second source vector |
| in_sel | input | 256 | Selector vector for the variable permutes |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_data | output | 256 | Registered result |
| out_err | output | 1 | Unused operation code |

## Verification
Every source dword carries a unique tag, so any wrong pick or swapped lane shows up directly. The immediates are chosen so that the two lanes and the two qword fields take different values. This separates reuse of the immediate across lanes from shifting it per lane.

The selector vectors set the high bits of every selector element. This shows that only the defined index bits steer the variable permutes. Half-route runs use the zero bit, both sources and both halves. They also use a narrow width flag to confirm that this operation still writes the full vector. Unused codes and idle cycles check the error flag and the held data.

// File: rtl/shp_pkg.sv
package shp_pkg;
    localparam int ELEM_W    = 32;
    localparam int LANE_W    = 128;
    localparam int NUM_LANES = 2;
    localparam int VEC_W     = LANE_W * NUM_LANES;
    localparam int IMM_W     = 8;
    localparam int OP_W      = 4;

    typedef enum logic [OP_W-1:0] {
        OP_MIX_LO   = 4'd0,
        OP_MIX_HI   = 4'd1,
        OP_PICK2_D  = 4'd2,
        OP_PICK2_Q  = 4'd3,
        OP_PERM_D   = 4'd4,
        OP_PERM_Q   = 4'd5,
        OP_VPERM_D  = 4'd6,
        OP_VPERM_Q  = 4'd7,
        OP_HALF     = 4'd8
    } op_e;
endpackage

// File: rtl/shp_lane.sv
module shp_lane #(
    parameter int LANE_IDX = 0,
    parameter int LW       = shp_pkg::LANE_W,
    parameter int EW       = shp_pkg::ELEM_W,
    parameter int IW       = shp_pkg::IMM_W,
    parameter int OW       = shp_pkg::OP_W
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic [LW-1:0] c,
    input  logic [IW-1:0] imm,
    input  logic [OW-1:0] op,
    output logic [LW-1:0] y
);
    import shp_pkg::*;

    localparam int ND = LW / EW;
    localparam int NQ = ND / 2;
    localparam int QW = 2 * EW;

    logic [EW-1:0] ad [ND];
    logic [EW-1:0] bd [ND];
    logic [EW-1:0] cd [ND];
    logic [QW-1:0] aq [NQ];
    logic [QW-1:0] bq [NQ];
    logic [IW-1:0] imm_q;

    for (genvar i = 0; i < ND; i++) begin : g_dw
        assign ad[i] = a[i*EW +: EW];
        assign bd[i] = b[i*EW +: EW];
        assign cd[i] = c[i*EW +: EW];
    end
    for (genvar j = 0; j < NQ; j++) begin : g_qw
        assign aq[j] = a[j*QW +: QW];
        assign bq[j] = b[j*QW +: QW];
    end

    // per-lane qword control: immediate advanced by two bits per lane
    assign imm_q = imm >> (2 * LANE_IDX);

    always_comb begin
        y = '0;
        case (op)
            OP_MIX_LO: begin
                for (int i = 0; i < ND/2; i++) begin
                    y[(2*i)*EW   +: EW] = ad[i];
                    y[(2*i+1)*EW +: EW] = bd[i];
                end
            end
            OP_MIX_HI: begin
                for (int i = 0; i < ND/2; i++) begin
                    y[(2*i)*EW   +: EW] = ad[ND/2+i];
                    y[(2*i+1)*EW +: EW] = bd[ND/2+i];
                end
            end
            OP_PICK2_D: begin
                for (int i = 0; i < ND; i++) begin
                    if (i < ND/2) y[i*EW +: EW] = ad[imm[2*i +: 2]];
                    else          y[i*EW +: EW] = bd[imm[2*i +: 2]];
                end
            end
            OP_PICK2_Q: begin
                y[0  +: QW] = aq[imm_q[0]];
                y[QW +: QW] = bq[imm_q[1]];
            end
            OP_PERM_D: begin
                for (int i = 0; i < ND; i++)
                    y[i*EW +: EW] = ad[imm[2*i +: 2]];
            end
            OP_PERM_Q: begin
                for (int j = 0; j < NQ; j++)
                    y[j*QW +: QW] = aq[imm_q[j]];
            end
            OP_VPERM_D: begin
                for (int i = 0; i < ND; i++)
                    y[i*EW +: EW] = ad[cd[i][1:0]];
            end
            OP_VPERM_Q: begin
                for (int j = 0; j < NQ; j++)
                    y[j*QW +: QW] = aq[cd[2*j][1]];
            end
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/shp_half_route.sv
module shp_half_route #(
    parameter int LW = shp_pkg::LANE_W,
    parameter int NL = shp_pkg::NUM_LANES,
    parameter int IW = shp_pkg::IMM_W
) (
    input  logic [LW*NL-1:0] a,
    input  logic [LW*NL-1:0] b,
    input  logic [IW-1:0]    imm,
    output logic [LW*NL-1:0] y
);
    for (genvar h = 0; h < NL; h++) begin : g_half
        logic [3:0]      nib;
        logic [LW-1:0]   lo_pick;
        logic [LW-1:0]   hi_pick;
        assign nib     = imm[4*h +: 4];
        assign lo_pick = nib[1] ? b[0 +: LW]  : a[0 +: LW];
        assign hi_pick = nib[1] ? b[LW +: LW] : a[LW +: LW];
        assign y[h*LW +: LW] = nib[3] ? '0 : (nib[0] ? hi_pick : lo_pick);
    end
endmodule

// File: rtl/shp_unit.sv
module shp_unit #(
    parameter int LANE_W    = shp_pkg::LANE_W,
    parameter int NUM_LANES = shp_pkg::NUM_LANES,
    parameter int IMM_W     = shp_pkg::IMM_W,
    parameter int OP_W      = shp_pkg::OP_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [OP_W-1:0]             in_op,
    input  logic                        in_wide,
    input  logic [IMM_W-1:0]            in_imm,
    input  logic [LANE_W*NUM_LANES-1:0] in_src_a,
    input  logic [LANE_W*NUM_LANES-1:0] in_src_b,
    input  logic [LANE_W*NUM_LANES-1:0] in_sel,
    output logic                        out_valid,
    output logic [LANE_W*NUM_LANES-1:0] out_data,
    output logic                        out_err
);
    import shp_pkg::*;

    localparam int VW = LANE_W * NUM_LANES;

    logic [VW-1:0] lane_y;
    logic [VW-1:0] half_y;
    logic [VW-1:0] nxt_data;
    logic          nxt_err;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        shp_lane #(
            .LANE_IDX (k),
            .LW       (LANE_W),
            .EW       (ELEM_W),
            .IW       (IMM_W),
            .OW       (OP_W)
        ) u_lane (
            .a   (in_src_a[k*LANE_W +: LANE_W]),
            .b   (in_src_b[k*LANE_W +: LANE_W]),
            .c   (in_sel[k*LANE_W +: LANE_W]),
            .imm (in_imm),
            .op  (in_op),
            .y   (lane_y[k*LANE_W +: LANE_W])
        );
    end

    shp_half_route #(
        .LW (LANE_W),
        .NL (NUM_LANES),
        .IW (IMM_W)
    ) u_half (
        .a   (in_src_a),
        .b   (in_src_b),
        .imm (in_imm),
        .y   (half_y)
    );

    always_comb begin
        nxt_err  = (in_op > OP_HALF);
        nxt_data = '0;
        if (in_op == OP_HALF) begin
            nxt_data = half_y;
        end else if (!nxt_err) begin
            nxt_data = lane_y;
            if (!in_wide) nxt_data[VW-1:LANE_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= nxt_data;
                out_err  <= nxt_err;
            end
        end
    end

    a_r1_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    a_r10_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide && in_op != OP_HALF) |=> (out_data[VW-1:LANE_W] == '0));
    a_r9_low_zeroed: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_HALF && in_imm[3]) |=> (out_data[LANE_W-1:0] == '0));
    a_r11_bad_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > OP_HALF) |=> (out_err && out_data == '0));
    a_r11_good_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op <= OP_HALF) |=> !out_err);
endmodule

// File: tb/test_shp_unit.sv
`timescale 1ns/1ps
module test_shp_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [3:0]   in_op;
    logic         in_wide;
    logic [7:0]   in_imm;
    logic [255:0] in_src_a, in_src_b, in_sel;
    logic         out_valid;
    logic [255:0] out_data;
    logic         out_err;

    int checks = 0;
    int errors = 0;
    logic [255:0] va, vb;

    always #10 clk = ~clk;

    shp_unit i_shp_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_imm(in_imm), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_sel(in_sel), .out_valid(out_valid),
        .out_data(out_data), .out_err(out_err)
    );

    function automatic logic [255:0] tagged_vec(input logic [15:0] tag);
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[32*k +: 32] = {tag, 16'h0100 + 16'(k)};
        return v;
    endfunction

    function automatic logic [31:0] dw(input logic [255:0] v, input int idx);
        return v[32*idx +: 32];
    endfunction

    // independent reference: walk result dwords one at a time
    function automatic logic [255:0] model(input logic [3:0] op, input logic [7:0] imm,
            input logic wide, input logic [255:0] a, input logic [255:0] b, input logic [255:0] c);
        logic [255:0] r;
        r = '0;
        for (int k = 0; k < 8; k++) begin
            int ln, p, q, hf, bt, s;
            logic [3:0] nib;
            logic [31:0] e;
            ln = k / 4; p = k % 4; q = p / 2; hf = p % 2; e = '0;
            case (op)
                4'd0: e = hf ? dw(b, 4*ln + q) : dw(a, 4*ln + q);
                4'd1: e = hf ? dw(b, 4*ln + 2 + q) : dw(a, 4*ln + 2 + q);
                4'd2: begin
                    s = int'(imm[2*p +: 2]);
                    e = (p < 2) ? dw(a, 4*ln + s) : dw(b, 4*ln + s);
                end
                4'd3: begin
                    bt = int'(imm[2*ln + q]);
                    e = (q == 0) ? dw(a, 4*ln + 2*bt + hf) : dw(b, 4*ln + 2*bt + hf);
                end
                4'd4: e = dw(a, 4*ln + int'(imm[2*p +: 2]));
                4'd5: begin
                    bt = int'(imm[2*ln + q]);
                    e = dw(a, 4*ln + 2*bt + hf);
                end
                4'd6: e = dw(a, 4*ln + int'(c[32*k +: 2]));
                4'd7: begin
                    bt = int'(c[32*(4*ln + 2*q) + 1]);
                    e = dw(a, 4*ln + 2*bt + hf);
                end
                4'd8: begin
                    nib = imm[4*ln +: 4];
                    if (!nib[3]) e = nib[1] ? dw(b, 4*int'(nib[0]) + p) : dw(a, 4*int'(nib[0]) + p);
                end
                default: e = '0;
            endcase
            if (!wide && op != 4'd8 && ln == 1) e = '0;
            r[32*k +: 32] = e;
        end
        return r;
    endfunction

    task automatic check_vec(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one request, result sampled at the negedge after the capturing posedge
    task automatic run(input string req, input logic [3:0] op, input logic [7:0] imm,
            input logic wide, input logic [255:0] a, input logic [255:0] b, input logic [255:0] c);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_imm = imm; in_wide = wide;
        in_src_a = a; in_src_b = b; in_sel = c;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({req, " valid"}, out_valid, 1'b1);
        check_vec(req, out_data, model(op, imm, wide, a, b, c));
        check_bit({req, " err"}, out_err, (op > 4'd8));
    endtask

    task automatic t_reset;
        check_bit("R1 reset valid", out_valid, 1'b0);
        check_vec("R1 reset data", out_data, '0);
        check_bit("R1 reset err", out_err, 1'b0);
    endtask

    task automatic t_interleave;
        run("R2 mix low", 4'd0, 8'h00, 1'b1, va, vb, '0);
        run("R3 mix high", 4'd1, 8'h00, 1'b1, va, vb, '0);
    endtask

    task automatic t_pick2;
        run("R4 pick2 dword 1B", 4'd2, 8'h1B, 1'b1, va, vb, '0);
        run("R4 pick2 dword 4E", 4'd2, 8'h4E, 1'b1, va, vb, '0);
        run("R5 pick2 qword 09", 4'd3, 8'h09, 1'b1, va, vb, '0);
        run("R5 pick2 qword 06", 4'd3, 8'h06, 1'b1, va, vb, '0);
    endtask

    task automatic t_perm_imm;
        run("R6 perm dword", 4'd4, 8'h1B, 1'b1, va, vb, '0);
        run("R6 perm qword", 4'd5, 8'h06, 1'b1, va, vb, '0);
    endtask

    task automatic t_perm_var;
        logic [255:0] c;
        for (int k = 0; k < 8; k++) c[32*k +: 32] = 32'hFFFF_FFFC | 32'((k * 3 + 1) % 4);
        run("R7 var perm dword", 4'd6, 8'hFF, 1'b1, va, vb, c);
        for (int k = 0; k < 8; k++) c[32*k +: 32] = (k == 2 || k == 4) ? 32'h7FFF_FFFF : 32'hFFFF_FFFD;
        run("R8 var perm qword", 4'd7, 8'h00, 1'b1, va, vb, c);
    endtask

    task automatic t_half;
        run("R9 half route 31", 4'd8, 8'h31, 1'b1, va, vb, '0);
        run("R9 half route zero low", 4'd8, 8'h0A, 1'b1, va, vb, '0);
        run("R9 R10 half route narrow", 4'd8, 8'h21, 1'b0, va, vb, '0);
    endtask

    task automatic t_narrow;
        run("R10 narrow mix low", 4'd0, 8'h00, 1'b0, va, vb, '0);
        run("R10 narrow perm dword", 4'd4, 8'hE4, 1'b0, va, vb, '0);
    endtask

    task automatic t_bad;
        run("R11 code 9", 4'd9, 8'h55, 1'b1, va, vb, va);
        run("R11 code 15", 4'd15, 8'hAA, 1'b1, va, vb, vb);
        run("R11 good after bad", 4'd1, 8'h00, 1'b1, va, vb, '0);
    endtask

    task automatic t_idle;
        logic [255:0] held;
        held = out_data;
        @(negedge clk);
        in_op = 4'd0; in_src_a = vb; in_src_b = va;
        @(negedge clk);
        check_bit("R1 idle valid", out_valid, 1'b0);
        check_vec("R1 idle hold", out_data, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        va = tagged_vec(16'hA0A0);
        vb = tagged_vec(16'hB0B0);
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_wide = 1'b1; in_imm = '0;
        in_src_a = '0; in_src_b = '0; in_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_interleave();
        t_pick2();
        t_perm_imm();
        t_perm_var();
        t_half();
        t_narrow();
        t_bad();
        t_idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule